// File: doc/BRIEF.md
# Quad I/O Read Flash Target

This block is the target side of a serial flash read port. It watches chip select, serial clock and four data lines from a host and answers one command: a read that takes its address and returns its data four bits per serial clock. Behind the port is a small on-chip byte array, which is filled through a separate synchronous write port. A read can start at any byte and run for as long as chip select stays low. The address steps after every byte and wraps to zero past the top of the array.

The block also tracks which command format is in use. After reset, commands arrive one bit per clock on line 0. A quad-enter command switches the port so that every later command arrives four bits per clock. The read is allowed in the one-bit command format only while the external quad-enable input is high. In the four-bit format it is always allowed.

All pins are oversampled in the system clock domain. The serial clock must stay at each level for at least four system clocks. Data lines are driven through a separate output enable.

Top module: `qspi_flash_target`

## Requirements
- R1: After reset the output enable is low, and the port expects one-bit command format.
- R2: In one-bit format with quad enable high, opcode EBh is sampled on line 0, MSB first, over 8 rising serial clock edges. It is followed by a 24-bit address taken as six nibbles on rising edges, MSB nibble first, with line 3 carrying the most significant bit of each nibble. The data then returned is the byte at that address.
- R3: The output enable stays low through the six dummy clocks. It goes high at the first falling edge after the sixth dummy rising edge. Each byte is sent high nibble first, and a new nibble is driven on each falling edge.
- R4: The address increments by one after every byte sent, so consecutive bytes come from consecutive addresses.
- R5: After the highest array address, the next byte comes from address zero.
- R6: In one-bit format with quad enable low, EBh is ignored and the output enable stays low until chip select rises.
- R7: Opcode 38h switches the port to four-bit command format, with the high nibble sent first. After that, EBh is accepted over two rising edges even when quad enable is low, and the format stays in force until reset.
- R8: Any other opcode is ignored until chip select rises, and the next command is decoded normally.
- R9: Chip select going high at any time drops the output enable, and the next command starts from a clean state.
- R10: In one-bit format, lines 1 to 3 have no effect on the opcode.
- R11: Address bits above the array width are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_dq_in | input | 4 | Data lines as seen at the pins |
| quad_en | input | 1 | Allows the quad read in one-bit command format |
| spi_dq_out | output | 4 | Data nibble to drive onto the lines |
| spi_dq_oe | output | 1 | Output enable for the data lines |
| fill_we | input | 1 | Array write strobe |
| fill_addr | input | ADDR_W | Array write address |
| fill_data | input | 8 | Array write byte |

## Verification
Every pin goes through two synchronizer stages and an edge register. Each result is therefore due three system clocks after the serial clock edge or chip-select change that causes it. This covers a new nibble after a falling edge, a rising output enable, and a dropped output enable after chip select rises. The bench holds each serial clock level for eight system clocks. It reads the data lines and output enable on the last falling system clock edge before it raises the serial clock, which is the same moment a host would sample. A chip-select release is checked eight clocks after it occurs. Inputs change only on falling system clock edges, so no check depends on the order of events at the sampling edge.

// File: rtl/qspi_flash_pkg.sv
package qspi_flash_pkg;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_IGNORE
  } phase_t;

  localparam logic [7:0] OPC_QUAD_READ  = 8'hEB;
  localparam logic [7:0] OPC_QUAD_ENTER = 8'h38;

endpackage

// File: rtl/qspi_pin_sync.sv
module qspi_pin_sync #(
  parameter int DQ_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sck_pin,
  input  logic            cs_n_pin,
  input  logic [DQ_W-1:0] dq_pin,
  output logic            sck_rise,
  output logic            sck_fall,
  output logic            cs_hi,
  output logic [DQ_W-1:0] dq_s
);

  logic            sck_m, sck_s, sck_p;
  logic            cs_m, cs_s;
  logic [DQ_W-1:0] dq_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_m <= 1'b0;
      sck_s <= 1'b0;
      sck_p <= 1'b0;
      cs_m  <= 1'b1;
      cs_s  <= 1'b1;
      dq_m  <= '0;
      dq_s  <= '0;
    end else begin
      sck_m <= sck_pin;
      sck_s <= sck_m;
      sck_p <= sck_s;
      cs_m  <= cs_n_pin;
      cs_s  <= cs_m;
      dq_m  <= dq_pin;
      dq_s  <= dq_m;
    end
  end

  assign sck_rise = sck_s & ~sck_p;
  assign sck_fall = ~sck_s & sck_p;
  assign cs_hi    = cs_s;

endmodule

// File: rtl/qspi_mem_array.sv
module qspi_mem_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/qspi_cmd_fsm.sv
module qspi_cmd_fsm
  import qspi_flash_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int ADDR_NIB  = 6,
  parameter int DUMMY_CYC = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_hi,
  input  logic [3:0]        dq_s,
  input  logic              quad_en,
  input  logic [7:0]        rdata,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [3:0]        dq_out,
  output logic              dq_oe
);

  localparam int CNT_TOP = (ADDR_NIB > DUMMY_CYC) ? ADDR_NIB : DUMMY_CYC;
  localparam int CNT_LIM = (CNT_TOP > 8) ? CNT_TOP : 8;
  localparam int CNT_W   = $clog2(CNT_LIM + 1);

  phase_t            phase;
  logic              qpi_mode;
  logic [6:0]        opc_q;
  logic [7:0]        opc_next;
  logic              cmd_last;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_next;
  logic              nib_lo;

  always_comb begin
    opc_next  = qpi_mode ? {opc_q[3:0], dq_s} : {opc_q, dq_s[0]};
    cmd_last  = qpi_mode ? (cnt == CNT_W'(1)) : (cnt == CNT_W'(7));
    addr_next = {addr_q[ADDR_W-5:0], dq_s};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_CMD;
      qpi_mode <= 1'b0;
      opc_q    <= '0;
      cnt      <= '0;
      addr_q   <= '0;
      rd_addr  <= '0;
      nib_lo   <= 1'b0;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
    end else if (cs_hi) begin
      phase  <= PH_CMD;
      cnt    <= '0;
      nib_lo <= 1'b0;
      dq_oe  <= 1'b0;
    end else begin
      case (phase)
        PH_CMD: if (sck_rise) begin
          opc_q <= opc_next[6:0];
          cnt   <= cnt + 1'b1;
          if (cmd_last) begin
            cnt <= '0;
            if (opc_next == OPC_QUAD_READ && (qpi_mode || quad_en)) begin
              phase <= PH_ADDR;
            end else begin
              if (opc_next == OPC_QUAD_ENTER) qpi_mode <= 1'b1;
              phase <= PH_IGNORE;
            end
          end
        end
        PH_ADDR: if (sck_rise) begin
          addr_q <= addr_next;
          cnt    <= cnt + 1'b1;
          if (cnt == CNT_W'(ADDR_NIB - 1)) begin
            cnt     <= '0;
            rd_addr <= addr_next;
            phase   <= PH_DUMMY;
          end
        end
        PH_DUMMY: if (sck_rise) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(DUMMY_CYC - 1)) begin
            cnt    <= '0;
            nib_lo <= 1'b0;
            phase  <= PH_DATA;
          end
        end
        PH_DATA: if (sck_fall) begin
          dq_oe <= 1'b1;
          if (!nib_lo) begin
            dq_out <= rdata[7:4];
            nib_lo <= 1'b1;
          end else begin
            dq_out  <= rdata[3:0];
            nib_lo  <= 1'b0;
            rd_addr <= rd_addr + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R9: a released chip select always takes the bus off
  assert_oe_drop_on_cs_R9: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> !dq_oe);

  // R3: the output enable only comes on at a falling serial clock edge
  assert_oe_rise_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> $past(sck_fall));

  // R3: driven data changes only in response to a falling edge
  assert_out_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && !$past(sck_fall)) |-> $stable(dq_out));

  // R4: the read address moves only on a falling edge during data
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && $past(phase == PH_DATA) && !$past(sck_fall)) |-> $stable(rd_addr));

  // R7: the four-bit command format is never left without reset
  assert_quad_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !$fell(qpi_mode));

endmodule

// File: rtl/qspi_flash_target.sv
module qspi_flash_target #(
  parameter int ADDR_W    = 11,
  parameter int ADDR_NIB  = 6,
  parameter int DUMMY_CYC = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic [3:0]        spi_dq_in,
  input  logic              quad_en,
  output logic [3:0]        spi_dq_out,
  output logic              spi_dq_oe,
  input  logic              fill_we,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [7:0]        fill_data
);

  logic              sck_rise, sck_fall, cs_hi;
  logic [3:0]        dq_s;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rdata;

  qspi_pin_sync #(.DQ_W(4)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sck_pin  (spi_sck),
    .cs_n_pin (spi_cs_n),
    .dq_pin   (spi_dq_in),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_hi    (cs_hi),
    .dq_s     (dq_s)
  );

  qspi_cmd_fsm #(
    .ADDR_W    (ADDR_W),
    .ADDR_NIB  (ADDR_NIB),
    .DUMMY_CYC (DUMMY_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_hi    (cs_hi),
    .dq_s     (dq_s),
    .quad_en  (quad_en),
    .rdata    (rdata),
    .rd_addr  (rd_addr),
    .dq_out   (spi_dq_out),
    .dq_oe    (spi_dq_oe)
  );

  qspi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk   (clk),
    .we    (fill_we),
    .waddr (fill_addr),
    .wdata (fill_data),
    .raddr (rd_addr),
    .rdata (rdata)
  );

endmodule

// File: tb/qspi_flash_target_tb.sv
module qspi_flash_target_tb;

  localparam int AW  = 11;
  localparam int TOP = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          spi_sck = 1'b0;
  logic          spi_cs_n = 1'b1;
  logic [3:0]    spi_dq_in = '0;
  logic          quad_en = 1'b0;
  logic [3:0]    spi_dq_out;
  logic          spi_dq_oe;
  logic          fill_we = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [7:0]    fill_data = '0;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  qspi_flash_target #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_dq_in(spi_dq_in), .quad_en(quad_en), .spi_dq_out(spi_dq_out),
    .spi_dq_oe(spi_dq_oe), .fill_we(fill_we), .fill_addr(fill_addr),
    .fill_data(fill_data)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [3:0] d, output logic [3:0] q, output logic oe);
    @(negedge clk);
    spi_sck = 1'b0;
    spi_dq_in = d;
    repeat (8) @(negedge clk);
    q = spi_dq_out;
    oe = spi_dq_oe;
    spi_sck = 1'b1;
    repeat (7) @(negedge clk);
  endtask

  task automatic cs_low();
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_high(input string req);
    @(negedge clk);
    spi_sck = 1'b0;
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check(req, spi_dq_oe, 1'b0);
  endtask

  task automatic send_spi_op(input logic [7:0] op, input logic [2:0] junk);
    logic [3:0] q; logic oe;
    for (int i = 7; i >= 0; i--) tick({junk ^ 3'(i), op[i]}, q, oe);
  endtask

  task automatic send_quad_op(input logic [7:0] op);
    logic [3:0] q; logic oe;
    tick(op[7:4], q, oe);
    tick(op[3:0], q, oe);
  endtask

  task automatic send_addr_dummy(input logic [23:0] a, input string req);
    logic [3:0] q; logic oe; int seen;
    seen = 0;
    for (int i = 5; i >= 0; i--) begin
      tick(a[i*4 +: 4], q, oe);
      if (oe) seen++;
    end
    for (int i = 0; i < 6; i++) begin
      tick(4'h0, q, oe);
      if (oe) seen++;
    end
    check(req, 32'(seen), 0);
  endtask

  task automatic read_bytes(input int start, input int n, input string req);
    logic [3:0] q; logic oe;
    int a;
    for (int k = 0; k < n; k++) begin
      a = (start + k) & TOP;
      tick(4'h0, q, oe);
      check(req, {oe, q}, {1'b1, pat(a)[7:4]});
      tick(4'h0, q, oe);
      check(req, {oe, q}, {1'b1, pat(a)[3:0]});
    end
  endtask

  task automatic expect_silent(input int n, input string req);
    logic [3:0] q; logic oe; int seen;
    seen = 0;
    for (int k = 0; k < n; k++) begin
      tick(4'hF, q, oe);
      if (oe) seen++;
    end
    check(req, 32'(seen), 0);
  endtask

  task automatic t_reset();
    check("R1 oe after reset", spi_dq_oe, 1'b0);
  endtask

  task automatic t_spi_read();
    quad_en = 1'b1;
    cs_low();
    send_spi_op(8'hEB, 3'b101);
    send_addr_dummy(24'h000123, "R3 oe low in addr/dummy");
    read_bytes(24'h123, 4, "R2 R4 R10 spi-format read");
    cs_high("R9 oe off at cs high");
  endtask

  task automatic t_qe_off();
    quad_en = 1'b0;
    cs_low();
    send_spi_op(8'hEB, 3'b000);
    expect_silent(20, "R6 EBh ignored with quad enable low");
    cs_high("R9 cs high after ignored read");
  endtask

  task automatic t_wrap();
    quad_en = 1'b1;
    cs_low();
    send_spi_op(8'hEB, 3'b111);
    send_addr_dummy(24'hABC7FE, "R3 oe low before data");
    read_bytes(TOP - 1, 4, "R5 R11 wrap and upper bits");
    cs_high("R9 cs high after wrap");
  endtask

  task automatic t_abort();
    logic [3:0] q; logic oe;
    quad_en = 1'b1;
    cs_low();
    send_spi_op(8'hEB, 3'b010);
    send_addr_dummy(24'h000040, "R3 oe low before abort");
    tick(4'h0, q, oe);
    check("R9 first nibble before abort", {oe, q}, {1'b1, pat(24'h40)[7:4]});
    cs_high("R9 oe drops mid-burst");
    cs_low();
    send_spi_op(8'hEB, 3'b001);
    send_addr_dummy(24'h000300, "R9 clean restart dummy");
    read_bytes(24'h300, 2, "R9 clean restart data");
    cs_high("R9 end of restart");
  endtask

  task automatic t_bad_op();
    quad_en = 1'b1;
    cs_low();
    send_spi_op(8'h03, 3'b000);
    expect_silent(20, "R8 unsupported opcode ignored");
    cs_high("R8 cs high after bad opcode");
    cs_low();
    send_spi_op(8'hEB, 3'b110);
    send_addr_dummy(24'h000555, "R8 next command dummy");
    read_bytes(24'h555, 2, "R8 next command decoded");
    cs_high("R8 end");
  endtask

  task automatic t_quad();
    quad_en = 1'b0;
    cs_low();
    send_spi_op(8'h38, 3'b000);
    cs_high("R7 after quad enter");
    cs_low();
    send_quad_op(8'hEB);
    send_addr_dummy(24'h0007F0, "R7 quad-format dummy");
    read_bytes(24'h7F0, 3, "R7 quad-format read with quad enable low");
    cs_high("R7 end of first quad read");
    cs_low();
    send_quad_op(8'hEB);
    send_addr_dummy(24'h000010, "R7 format persists dummy");
    read_bytes(24'h10, 1, "R7 format persists");
    cs_high("R7 end");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a <= TOP; a++) begin
      @(negedge clk);
      fill_we = 1'b1;
      fill_addr = AW'(a);
      fill_data = pat(a);
    end
    @(negedge clk);
    fill_we = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_spi_read();
    t_qe_off();
    t_wrap();
    t_abort();
    t_bad_op();
    t_quad();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule